// File: doc/BRIEF.md
# FIFO event status flag register

This block keeps a set of sticky event flags for the transmit and receive FIFOs of a serial shift controller. It watches the push and pop strobes together with the full and empty indications of both FIFOs, the transmit fill level against a programmable trigger level, and a pulse from the shift engine that marks the end of a transfer. Each watched condition latches a flag bit in a 32-bit status word. The bit stays set until software writes a one to it.

Software reads the status word directly. It clears flags by presenting a write strobe with a data word: each one in the data clears the matching flag, and each zero leaves its flag as it is. If a flag's set condition is true in the same cycle as its clear, the set takes precedence. A level condition that is still true therefore brings its flag back right after a clear. An interrupt request is raised whenever any flag that is set is also enabled in a mask with the same bit layout.

Reset is asserted asynchronously and released through a two-stage synchronizer. The status word holds its reset value until the third rising clock edge after the reset input goes high.

Top module: `fifo_evt_status`

## Requirements
- R1: The error flags are sticky. Bit 10 sets on a cycle where tx_push and tx_full are both high (transmit overflow). Bit 11 sets on a cycle where tx_pop and tx_empty are both high (transmit underrun). Bit 8 sets on a cycle where rx_push and rx_full are both high (receive overflow). Bit 9 sets on a cycle where rx_pop and rx_empty are both high (receive underrun).
- R2: On a cycle with wr_en high, each bit of wr_data that is 1 clears the matching flag. Bits of wr_data that are 0 leave their flags unchanged. With wr_en low, no flag is cleared.
- R3: Bit 6 sets on any cycle with tx_full high. Bit 2 sets on any cycle with rx_full high. Both stay set until cleared.
- R4: Bit 5 sets on any cycle with tx_empty high and stays set until cleared.
- R5: Bit 4 sets on any cycle where tx_level is less than or equal to tx_trig, compared as unsigned numbers. Equality counts as a set condition.
- R6: Bit 12 sets on a cycle with xfer_done high and stays set until cleared.
- R7: Every status bit other than 2, 4, 5, 6 and 8 to 12 reads 0, whatever wr_data holds.
- R8: When a flag's set condition and its clear occur in the same cycle, the flag is 1 after that cycle.
- R9: While rst_n is low, status reads 32'h0000_0020. After rst_n rises, the first flag update happens on the third rising clock edge.
- R10: irq is high exactly when (status AND int_en) is nonzero. It follows int_en in the same cycle, without a clock edge.
- R11: A flag whose condition is true on a sampling edge reads 1 right after that edge. The status word changes on no other edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_level | input | LVL_W | Transmit FIFO fill level |
| tx_trig | input | LVL_W | Transmit trigger level |
| tx_push | input | 1 | Transmit FIFO write strobe |
| tx_pop | input | 1 | Transmit FIFO read strobe |
| tx_full | input | 1 | Transmit FIFO full indication |
| tx_empty | input | 1 | Transmit FIFO empty indication |
| rx_push | input | 1 | Receive FIFO write strobe |
| rx_pop | input | 1 | Receive FIFO read strobe |
| rx_full | input | 1 | Receive FIFO full indication |
| rx_empty | input | 1 | Receive FIFO empty indication |
| xfer_done | input | 1 | End-of-transfer pulse from the shift engine |
| wr_en | input | 1 | Write strobe of the clear port |
| wr_data | input | 32 | Write-one-to-clear data |
| int_en | input | 32 | Interrupt enable mask, same layout as status |
| status | output | 32 | Status flag word |
| irq | output | 1 | Interrupt request |

## Verification
A set condition or a clear is sampled on a rising edge, so the flag reads its new value half a cycle later. The interrupt request follows the mask without waiting for any edge. After reset is released, the first flag update lands on the third rising edge. The bench changes its inputs only on falling edges. Its reference model updates on each rising edge, holding back for the two synchronizer edges after reset release. Every output is compared on the next falling edge, which keeps each sample exactly one register stage after its stimulus and puts int_en changes in the same half cycle as their effect on irq.

// File: rtl/fifo_evt_pkg.sv
package fifo_evt_pkg;

  localparam int STAT_W = 32;

  // flag positions inside the status word
  localparam int B_RX_FULL = 2;
  localparam int B_TX_RDY  = 4;
  localparam int B_TX_EMP  = 5;
  localparam int B_TX_FULL = 6;
  localparam int B_RX_OVF  = 8;
  localparam int B_RX_UDF  = 9;
  localparam int B_TX_OVF  = 10;
  localparam int B_TX_UDF  = 11;
  localparam int B_DONE    = 12;

  function automatic logic [STAT_W-1:0] bit_at(input int pos);
    logic [STAT_W-1:0] v;
    v      = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  localparam logic [STAT_W-1:0] FLAG_MASK =
      bit_at(B_RX_FULL) | bit_at(B_TX_RDY) | bit_at(B_TX_EMP) |
      bit_at(B_TX_FULL) | bit_at(B_RX_OVF) | bit_at(B_RX_UDF) |
      bit_at(B_TX_OVF)  | bit_at(B_TX_UDF) | bit_at(B_DONE);

  localparam logic [STAT_W-1:0] RESET_VAL = bit_at(B_TX_EMP);

endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;
  logic [STAGES-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/evt_detect.sv
module evt_detect
  import fifo_evt_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic [LVL_W-1:0]  tx_level,
  input  logic [LVL_W-1:0]  tx_trig,
  input  logic              tx_push,
  input  logic              tx_pop,
  input  logic              tx_full,
  input  logic              tx_empty,
  input  logic              rx_push,
  input  logic              rx_pop,
  input  logic              rx_full,
  input  logic              rx_empty,
  input  logic              xfer_done,
  output logic [STAT_W-1:0] set_vec
);
  always_comb begin
    set_vec            = '0;
    set_vec[B_TX_OVF]  = tx_push & tx_full;
    set_vec[B_TX_UDF]  = tx_pop  & tx_empty;
    set_vec[B_RX_OVF]  = rx_push & rx_full;
    set_vec[B_RX_UDF]  = rx_pop  & rx_empty;
    set_vec[B_TX_FULL] = tx_full;
    set_vec[B_RX_FULL] = rx_full;
    set_vec[B_TX_EMP]  = tx_empty;
    set_vec[B_TX_RDY]  = (tx_level <= tx_trig);
    set_vec[B_DONE]    = xfer_done;
  end
endmodule

// File: rtl/evt_sticky_bit.sv
module evt_sticky_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic en;

  always_comb begin
    en  = set_i | clr_i;
    q_d = set_i | (q_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_q <= RST_VAL;
    else if (en) q_q <= q_d;
  end

  assign q_o = q_q;

  // R2
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && q_o) |=> q_o);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate
  import fifo_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status,
  input  logic [STAT_W-1:0] int_en,
  output logic              irq
);
  logic [STAT_W-1:0] hit;

  always_comb begin
    hit = status & int_en;
    irq = |hit;
  end

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == '0) |-> !irq);
  // R10
  irq_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == '0) |-> !irq);
endmodule

// File: rtl/fifo_evt_status.sv
module fifo_evt_status
  import fifo_evt_pkg::*;
#(
  parameter int LVL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] tx_level,
  input  logic [LVL_W-1:0] tx_trig,
  input  logic             tx_push,
  input  logic             tx_pop,
  input  logic             tx_full,
  input  logic             tx_empty,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             rx_full,
  input  logic             rx_empty,
  input  logic             xfer_done,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic [31:0]      int_en,
  output logic [31:0]      status,
  output logic             irq
);
  logic              rst_int_n;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] status_q;
  logic              unused_bits;

  evt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  evt_detect #(.LVL_W(LVL_W)) u_detect (
    .tx_level  (tx_level),
    .tx_trig   (tx_trig),
    .tx_push   (tx_push),
    .tx_pop    (tx_pop),
    .tx_full   (tx_full),
    .tx_empty  (tx_empty),
    .rx_push   (rx_push),
    .rx_pop    (rx_pop),
    .rx_full   (rx_full),
    .rx_empty  (rx_empty),
    .xfer_done (xfer_done),
    .set_vec   (set_vec)
  );

  always_comb begin
    clr_vec = wr_en ? wr_data : '0;
  end

  for (genvar b = 0; b < STAT_W; b++) begin : g_bit
    if (FLAG_MASK[b]) begin : g_flag
      evt_sticky_bit #(.RST_VAL(RESET_VAL[b])) u_flag (
        .clk   (clk),
        .rst_n (rst_int_n),
        .set_i (set_vec[b]),
        .clr_i (clr_vec[b]),
        .q_o   (status_q[b])
      );
    end else begin : g_rsvd
      assign status_q[b] = 1'b0;
    end
  end

  assign unused_bits = ^((clr_vec | set_vec) & ~FLAG_MASK);
  assign status      = status_q;

  evt_irq_gate u_irq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .status (status_q),
    .int_en (int_en),
    .irq    (irq)
  );

  // R1
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_push && tx_full) |=> status[B_TX_OVF]);
  // R1
  rx_udf_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rx_pop && rx_empty) |=> status[B_RX_UDF]);
  // R4
  tx_emp_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_empty |=> status[B_TX_EMP]);
  // R5
  tx_rdy_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (tx_level <= tx_trig) |=> status[B_TX_RDY]);
  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    xfer_done |=> status[B_DONE]);
  // R11
  quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!wr_en && !tx_full && !rx_full && !tx_empty && !xfer_done &&
     (tx_level > tx_trig) && !(rx_pop && rx_empty) && !(tx_pop && tx_empty))
    |=> $stable(status));
endmodule

// File: tb/fifo_evt_status_tb_top.sv
module fifo_evt_status_tb_top;
  localparam int LW = 7;
  localparam logic [31:0] FLAGS = 32'h0000_1F74;

  logic clk = 1'b0;
  logic rst_n;
  logic [LW-1:0] tx_level, tx_trig;
  logic tx_push, tx_pop, tx_full, tx_empty;
  logic rx_push, rx_pop, rx_full, rx_empty;
  logic xfer_done, wr_en, irq;
  logic [31:0] wr_data, int_en, status;

  int checks = 0;
  int errors = 0;
  bit done_run = 0;

  logic [31:0] model;
  int live;

  always #2 clk = ~clk;

  fifo_evt_status #(.LVL_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_level(tx_level), .tx_trig(tx_trig),
    .tx_push(tx_push), .tx_pop(tx_pop), .tx_full(tx_full), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_pop(rx_pop), .rx_full(rx_full), .rx_empty(rx_empty),
    .xfer_done(xfer_done), .wr_en(wr_en), .wr_data(wr_data), .int_en(int_en),
    .status(status), .irq(irq)
  );

  // behavioural reference: apply set/clear rule on each rising edge
  always @(posedge clk or negedge rst_n) begin
    logic [31:0] s, c;
    if (!rst_n) begin
      model = 32'h0000_0020;
      live  = 0;
    end else begin
      if (live >= 2) begin
        s = 32'h0;
        if (tx_push && tx_full)  s = s | 32'h400;
        if (tx_pop && tx_empty)  s = s | 32'h800;
        if (rx_push && rx_full)  s = s | 32'h100;
        if (rx_pop && rx_empty)  s = s | 32'h200;
        if (tx_full)             s = s | 32'h40;
        if (rx_full)             s = s | 32'h4;
        if (tx_empty)            s = s | 32'h20;
        if (int'(tx_level) <= int'(tx_trig)) s = s | 32'h10;
        if (xfer_done)           s = s | 32'h1000;
        c = wr_en ? wr_data : 32'h0;
        model = ((model & ~c) | s) & FLAGS;
      end
      if (live < 3) live++;
    end
  end

  task automatic cmp(input string tag, input logic [31:0] mask);
    checks++;
    if ((status & mask) !== (model & mask)) begin
      errors++;
      $display("FAIL %s status&%h actual %h expected %h", tag, mask,
               status & mask, model & mask);
    end
  endtask

  task automatic check_all();
    logic exp_irq;
    cmp("R1", 32'h0F00);
    cmp("R3", 32'h0044);
    cmp("R4", 32'h0020);
    cmp("R5", 32'h0010);
    cmp("R6", 32'h1000);
    cmp("R7", ~FLAGS);
    cmp("R11", 32'hFFFF_FFFF);
    exp_irq = |(model & int_en);
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL R10 irq actual %b expected %b", irq, exp_irq);
    end
  endtask

  task automatic next_cycle();
    @(negedge clk);
    check_all();
  endtask

  task automatic expect_status(input string tag, input logic [31:0] exp);
    checks++;
    if (status !== exp) begin
      errors++;
      $display("FAIL %s status actual %h expected %h", tag, status, exp);
    end
  endtask

  task automatic idle();
    tx_level = 7'd5; tx_trig = 7'd2;
    tx_push = 0; tx_pop = 0; tx_full = 0; tx_empty = 0;
    rx_push = 0; rx_pop = 0; rx_full = 0; rx_empty = 0;
    xfer_done = 0; wr_en = 0; wr_data = 32'h0;
  endtask

  task automatic clear_write(input logic [31:0] d);
    wr_en = 1; wr_data = d;
    next_cycle();
    wr_en = 0; wr_data = 32'h0;
  endtask

  initial begin
    rst_n = 0;
    int_en = 32'h0;
    idle();
    tx_empty = 1; tx_level = 7'd0; tx_trig = 7'd0;
    repeat (3) @(negedge clk);
    expect_status("R9", 32'h0000_0020);
    rst_n = 1;
    // conditions active during the two sync edges must not register
    @(negedge clk); expect_status("R9", 32'h0000_0020);
    @(negedge clk); expect_status("R9", 32'h0000_0020);
    idle();
    next_cycle();
    expect_status("R9", 32'h0000_0020);

    clear_write(32'hFFFF_FFFF);
    expect_status("R2", 32'h0);

    tx_push = 1; tx_full = 1;
    next_cycle();
    idle();
    expect_status("R1", 32'h0000_0440);
    next_cycle();
    expect_status("R1", 32'h0000_0440);

    clear_write(32'h0000_0400);
    expect_status("R2", 32'h0000_0040);
    clear_write(32'h0);
    expect_status("R2", 32'h0000_0040);
    wr_en = 0; wr_data = 32'h0000_0040;
    next_cycle();
    expect_status("R2", 32'h0000_0040);

    tx_full = 1;
    clear_write(32'h0000_0040);
    tx_full = 0;
    expect_status("R8", 32'h0000_0040);
    clear_write(32'h0000_0040);
    expect_status("R8", 32'h0);

    clear_write(32'hFFFF_E08B);
    expect_status("R7", 32'h0);

    tx_level = 7'd3; tx_trig = 7'd2;
    next_cycle();
    expect_status("R5", 32'h0);
    tx_level = 7'd2;
    next_cycle();
    idle();
    expect_status("R5", 32'h0000_0010);
    clear_write(32'h10);

    xfer_done = 1;
    next_cycle();
    xfer_done = 0;
    expect_status("R6", 32'h0000_1000);
    int_en = 32'h0000_1000;
    #1;
    checks++;
    if (irq !== 1'b1) begin errors++; $display("FAIL R10 irq actual %b expected 1", irq); end
    int_en = 32'h0000_0001;
    #1;
    checks++;
    if (irq !== 1'b0) begin errors++; $display("FAIL R10 irq actual %b expected 0", irq); end
    next_cycle();

    rx_pop = 1; rx_empty = 1; tx_pop = 1; tx_empty = 1;
    next_cycle();
    idle();
    expect_status("R1", 32'h0000_1A20);
    rx_push = 1; rx_full = 1;
    next_cycle();
    idle();
    expect_status("R3", 32'h0000_1B24);

    for (int i = 0; i < 3000; i++) begin
      tx_push = ($urandom % 4) == 0; tx_pop = ($urandom % 4) == 0;
      tx_full = ($urandom % 5) == 0; tx_empty = ($urandom % 5) == 0;
      rx_push = ($urandom % 4) == 0; rx_pop = ($urandom % 4) == 0;
      rx_full = ($urandom % 5) == 0; rx_empty = ($urandom % 5) == 0;
      xfer_done = ($urandom % 16) == 0;
      tx_level = 7'($urandom % 16); tx_trig = 7'($urandom % 16);
      wr_en = ($urandom % 3) == 0; wr_data = $urandom;
      if ((i % 37) == 0) int_en = $urandom;
      if (i == 1500) begin
        rst_n = 0;
        #1;
        expect_status("R9", 32'h0000_0020);
        next_cycle();
        rst_n = 1;
      end
      next_cycle();
    end

    done_run = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done_run) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule